// File: doc/BRIEF.md
# Signed-Digit Tree Multiplier

This block multiplies two N-bit integers, N being a power of two (8 by default). A mode input chooses between unsigned and two's complement operands. Both operands are first rewritten as signed-digit numbers, where every digit is -1, 0 or +1. Each multiplier digit then selects one partial product: zero, the multiplicand, or the negated multiplicand, shifted left by the digit's position.

The partial products are reduced two at a time through a balanced tree of log2(N) levels of carry-free signed-digit adders. Each sum digit of such an adder depends only on a short window of nearby input digits, so the delay of a level does not grow with the word width. A carry ripples only once, in the last step, where the root sum is turned back into binary by taking the positive-digit vector minus the negative-digit vector.

The 2N-bit result is captured in an output register that is cleared by a synchronous reset. An operand pair presented before a rising edge shows up on the output after that edge.

Top module: `rbt_mult`

## Requirements
- R1: While `rst` is high at a rising edge, `prod_q` is loaded with zero.
- R2: `prod_q` is loaded only at a rising edge. After the edge it holds the product of the operands and mode that were present just before that edge, and it does not move while the inputs change between edges.
- R3: With `twos_mode` = 0, `prod_q` equals op_a × op_b, with both operands read as unsigned and the result 2N bits wide.
- R4: With `twos_mode` = 1, `prod_q` equals op_a × op_b, with both operands read as two's complement. The result is 2N-1 bits wide and is sign-extended to 2N bits. An operand equal to -2^(N-1) is outside the supported range, and the result for it is not specified.
- R5: At the root of the adder tree, a digit is carried as a (plus, minus) bit pair, with 0 = 00, +1 = 10 and -1 = 01. The pair 11 never appears.
- R6: If either operand is zero, the next `prod_q` is zero in both modes.
- R7: If op_b = 1, the next `prod_q` equals op_a. In unsigned mode op_a is zero-extended, and in two's complement mode it is sign-extended.
- R8: In two's complement mode with op_b all ones (-1), the next `prod_q` equals the 2N-bit negation of the sign-extended op_a.
- R9: For N = 4 in two's complement mode, -3 × -5 (op_a = 4'hD, op_b = 4'hB) yields 8'h0F.
- R10: In unsigned mode, all-ones × all-ones yields (2^N - 1)^2, which has the top product bit set: 16'hFE01 for N = 8 and 8'hE1 for N = 4.
- R11: In two's complement mode, the largest positive value squared and the largest positive value times -(2^(N-1) - 1) give correct results: 16'h3F01 and 16'hC0FF for N = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| twos_mode | input | 1 | 0 = unsigned operands, 1 = two's complement operands |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| prod_q | output | 2N | Registered product |

## Verification
The 4-bit configuration is swept over every operand pair in both modes. This reaches every sign combination of the top digit, which is where a wrong recode of the top bit would give products that are off by a multiple of 2^(N-1).

The 8-bit configuration gets random pairs plus fixed corners: zero, one, all ones, the largest positive value, and the unsigned half-scale value. All-ones squared drives a digit into the top product position. A tree that dropped or mis-weighted that digit would get the high byte wrong, and an adder with a wrong carry rule for lone ±1 digits would leave an error of one unit at some power of two.

Multiplying by one and by minus one exposes any asymmetry in the negation by plus/minus swap. Pairs that use -2^(N-1) are counted as unsupported and are left unchecked.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  // One signed digit as a {plus, minus} pair: 00 = 0, 10 = +1, 01 = -1.
  typedef logic [1:0] sdig_t;

  function automatic logic signed [2:0] sd_val(input sdig_t d);
    return $signed({2'b00, d[1]}) - $signed({2'b00, d[0]});
  endfunction

  function automatic sdig_t sd_enc(input logic signed [2:0] v);
    return {v == 3'sd1, v == -3'sd1};
  endfunction
endpackage

// File: rtl/rbt_ppgen.sv
module rbt_ppgen #(
  parameter int N = 8,
  localparam int OW = 2 * N
) (
  input  logic          twos_mode,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic [OW-1:0] pp_pos [N],
  output logic [OW-1:0] pp_neg [N]
);
  logic [N-1:0] a_pos, a_neg, b_pos, b_neg;

  // Recode: unsigned bits map straight across; in two's complement the top bit is a -1 digit.
  assign a_pos = twos_mode ? {1'b0, op_a[N-2:0]} : op_a;
  assign a_neg = twos_mode ? {op_a[N-1], {(N-1){1'b0}}} : '0;
  assign b_pos = twos_mode ? {1'b0, op_b[N-2:0]} : op_b;
  assign b_neg = twos_mode ? {op_b[N-1], {(N-1){1'b0}}} : '0;

  for (genvar j = 0; j < N; j++) begin : g_row
    logic [OW-1:0] wa_pos, wa_neg;
    assign wa_pos = {{N{1'b0}}, a_pos} << j;
    assign wa_neg = {{N{1'b0}}, a_neg} << j;
    // A -1 multiplier digit negates the multiplicand by swapping the digit halves.
    assign pp_pos[j] = b_pos[j] ? wa_pos : (b_neg[j] ? wa_neg : '0);
    assign pp_neg[j] = b_pos[j] ? wa_neg : (b_neg[j] ? wa_pos : '0);
  end
endmodule

// File: rtl/rbt_sd_add.sv
module rbt_sd_add
  import rbt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_pos,
  input  logic [W-1:0] x_neg,
  input  logic [W-1:0] y_pos,
  input  logic [W-1:0] y_neg,
  output logic [W-1:0] z_pos,
  output logic [W-1:0] z_neg
);
  logic [W-1:0] c_pos, c_neg, s_pos, s_neg;
  logic [W-1:0] lx_neg, ly_neg, ci_pos, ci_neg;

  // Negative-digit flags of the next lower position; below digit 0 everything reads as zero.
  assign lx_neg = {x_neg[W-2:0], 1'b0};
  assign ly_neg = {y_neg[W-2:0], 1'b0};

  // First step: split each digit sum into a carry and an interim digit.
  always_comb begin
    logic signed [2:0] t;
    logic nn;
    for (int i = 0; i < W; i++) begin
      t  = sd_val({x_pos[i], x_neg[i]}) + sd_val({y_pos[i], y_neg[i]});
      nn = ~(lx_neg[i] | ly_neg[i]);
      {c_pos[i], c_neg[i], s_pos[i], s_neg[i]} = 4'b0000;
      case (t)
        3'sd2:  c_pos[i] = 1'b1;
        -3'sd2: c_neg[i] = 1'b1;
        3'sd1:  if (nn) {c_pos[i], s_neg[i]} = 2'b11; else s_pos[i] = 1'b1;
        -3'sd1: if (nn) s_neg[i] = 1'b1; else {c_neg[i], s_pos[i]} = 2'b11;
        default: ;
      endcase
    end
  end

  // Carries move up one position; the carry out of the top digit is dropped (result taken modulo 2^W).
  assign ci_pos = {c_pos[W-2:0], 1'b0};
  assign ci_neg = {c_neg[W-2:0], 1'b0};

  // Second step: interim digit plus incoming carry, which always stays inside {-1, 0, 1}.
  always_comb begin
    logic signed [2:0] v;
    for (int i = 0; i < W; i++) begin
      v = sd_val({s_pos[i], s_neg[i]}) + sd_val({ci_pos[i], ci_neg[i]});
      {z_pos[i], z_neg[i]} = sd_enc(v);
    end
  end
endmodule

// File: rtl/rbt_sd2bin.sv
module rbt_sd2bin #(
  parameter int W = 16
) (
  input  logic [W-1:0] d_pos,
  input  logic [W-1:0] d_neg,
  output logic [W-1:0] bin
);
  // The only carry chain in the block: positive digits minus negative digits.
  assign bin = d_pos - d_neg;
endmodule

// File: rtl/rbt_mult.sv
module rbt_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           twos_mode,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod_q
);
  localparam int OW = 2 * N;
  localparam int LV = $clog2(N);

  logic [OW-1:0] pp_pos [N];
  logic [OW-1:0] pp_neg [N];
  logic [OW-1:0] root_pos, root_neg, prod_d;

  rbt_ppgen #(.N(N)) u_ppgen (
    .twos_mode(twos_mode),
    .op_a(op_a),
    .op_b(op_b),
    .pp_pos(pp_pos),
    .pp_neg(pp_neg)
  );

  // Level l holds N >> l signed-digit values; node j of level l sums nodes 2j and 2j+1 of level l-1.
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int CNT = N >> l;
    logic [OW-1:0] s_pos [CNT];
    logic [OW-1:0] s_neg [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_pp
        assign s_pos[j] = pp_pos[j];
        assign s_neg[j] = pp_neg[j];
      end
    end else begin : g_add
      for (genvar j = 0; j < CNT; j++) begin : g_node
        rbt_sd_add #(.W(OW)) u_add (
          .x_pos(g_lvl[l-1].s_pos[2*j]),
          .x_neg(g_lvl[l-1].s_neg[2*j]),
          .y_pos(g_lvl[l-1].s_pos[2*j+1]),
          .y_neg(g_lvl[l-1].s_neg[2*j+1]),
          .z_pos(s_pos[j]),
          .z_neg(s_neg[j])
        );
      end
    end
  end

  assign root_pos = g_lvl[LV].s_pos[0];
  assign root_neg = g_lvl[LV].s_neg[0];

  rbt_sd2bin #(.W(OW)) u_conv (
    .d_pos(root_pos),
    .d_neg(root_neg),
    .bin(prod_d)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= prod_d;
  end
endmodule

// File: rtl/rbt_mult_chk.sv
module rbt_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           twos_mode,
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod_q,
  input logic [2*N-1:0] root_pos,
  input logic [2*N-1:0] root_neg
);
  localparam int OW = 2 * N;

  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prod_q == '0);

  assert_digit_code_R5: assert property (@(posedge clk) disable iff (rst)
    (root_pos & root_neg) == '0);

  assert_zero_operand_R6: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 || op_b == '0) |=> prod_q == '0);

  assert_unit_multiplier_R7: assert property (@(posedge clk) disable iff (rst)
    (op_b == N'(1)) |=> prod_q == (($past(twos_mode) && $past(op_a[N-1]))
                                    ? {{N{1'b1}}, $past(op_a)} : {{N{1'b0}}, $past(op_a)}));

  assert_minus_one_R8: assert property (@(posedge clk) disable iff (rst)
    (twos_mode && op_b == '1) |=> prod_q == (OW'(0) - {{N{$past(op_a[N-1])}}, $past(op_a)}));
endmodule

bind rbt_mult rbt_mult_chk #(.N(N)) u_rbt_mult_chk (
  .clk(clk),
  .rst(rst),
  .twos_mode(twos_mode),
  .op_a(op_a),
  .op_b(op_b),
  .prod_q(prod_q),
  .root_pos(root_pos),
  .root_neg(root_neg)
);

// File: tb/test_rbt_mult.sv
module test_rbt_mult;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic twos = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [15:0] p8;
  logic [7:0]  p4;
  int checks = 0, errors = 0, skipped = 0;

  always #4 clk = ~clk;

  rbt_mult #(.N(8)) i_rbt_mult (
    .clk(clk), .rst(rst), .twos_mode(twos), .op_a(a8), .op_b(b8), .prod_q(p8));
  rbt_mult #(.N(4)) i_rbt_mult_n4 (
    .clk(clk), .rst(rst), .twos_mode(twos), .op_a(a4), .op_b(b4), .prod_q(p4));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference product, computed arithmetically and reduced to 2n bits.
  function automatic logic [15:0] refp(input int n, input bit m, input longint a, input longint b);
    longint sa = a, sb = b, p;
    if (m && a >= (64'sd1 <<< (n - 1))) sa = a - (64'sd1 <<< n);
    if (m && b >= (64'sd1 <<< (n - 1))) sb = b - (64'sd1 <<< n);
    p = sa * sb;
    return 16'(p & ((64'sd1 <<< (2 * n)) - 1));
  endfunction

  task automatic cycle(input bit m, input logic [7:0] x8, input logic [7:0] y8,
                       input logic [3:0] x4, input logic [3:0] y4);
    @(negedge clk);
    twos = m; a8 = x8; b8 = y8; a4 = x4; b4 = y4;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pick8(input bit m);
    logic [7:0] v = 8'($urandom);
    if (m && v == 8'h80) v = 8'h81;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] c8 [6];
    c8 = '{8'h00, 8'h01, 8'h7F, 8'hFF, 8'h80, 8'h55};
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset n8", p8, 16'h0);
    check("R1 reset n4", {8'h0, p4}, 16'h0);
    @(negedge clk) rst = 1'b0;

    // R9: the worked 4-bit signed example
    cycle(1'b1, 8'h03, 8'h05, 4'hD, 4'hB);
    check("R9 -3*-5 n4", {8'h0, p4}, 16'h000F);
    check("R4 3*5 n8", p8, 16'h000F);

    // R2: output holds between edges while inputs change
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF; a4 = 4'h7; twos = 1'b0;
    #1;
    check("R2 hold n8", p8, 16'h000F);
    check("R2 hold n4", {8'h0, p4}, 16'h000F);
    @(posedge clk); #1;
    check("R2 update n8", p8, 16'hFE01);

    // Exhaustive 4-bit sweep in both modes, random 8-bit pairs alongside
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [7:0] x = pick8(m[0]);
          logic [7:0] y = pick8(m[0]);
          cycle(m[0], x, y, 4'(a), 4'(b));
          check(m ? "R4 rand n8" : "R3 rand n8", p8, refp(8, m[0], longint'(x), longint'(y)));
          if (m == 1 && (a == 8 || b == 8)) skipped++;
          else check(m ? "R4 sweep n4" : "R3 sweep n4", {8'h0, p4}, refp(4, m[0], a, b));
        end
      end
    end
    $display("note: %0d unsupported full-scale negative pairs left unchecked", skipped);

    // 8-bit corner grid
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 6; i++) begin
        for (int k = 0; k < 6; k++) begin
          if (m == 1 && (c8[i] == 8'h80 || c8[k] == 8'h80)) continue;
          cycle(m[0], c8[i], c8[k], 4'h0, 4'h0);
          check(m ? "R4 corner n8" : "R3 corner n8", p8, refp(8, m[0], c8[i], c8[k]));
        end
      end
    end

    // More random 8-bit pairs
    for (int r = 0; r < 3000; r++) begin
      bit m = r[0];
      logic [7:0] x = pick8(m);
      logic [7:0] y = pick8(m);
      cycle(m, x, y, 4'h0, 4'h0);
      check(m ? "R4 random n8" : "R3 random n8", p8, refp(8, m, x, y));
    end

    cycle(1'b0, 8'h00, 8'hFF, 4'hF, 4'h0);
    check("R6 zero a n8", p8, 16'h0);
    check("R6 zero b n4", {8'h0, p4}, 16'h0);
    cycle(1'b1, 8'hA7, 8'h01, 4'hA, 4'h1);
    check("R7 unit signed n8", p8, 16'hFFA7);
    check("R7 unit signed n4", {8'h0, p4}, 16'h00FA);
    cycle(1'b0, 8'hA7, 8'h01, 4'hA, 4'h1);
    check("R7 unit unsigned n8", p8, 16'h00A7);
    cycle(1'b1, 8'h35, 8'hFF, 4'h3, 4'hF);
    check("R8 minus one n8", p8, 16'hFFCB);
    check("R8 minus one n4", {8'h0, p4}, 16'h00FD);
    cycle(1'b0, 8'hFF, 8'hFF, 4'hF, 4'hF);
    check("R10 all ones n8", p8, 16'hFE01);
    check("R10 all ones n4", {8'h0, p4}, 16'h00E1);
    cycle(1'b1, 8'h7F, 8'h7F, 4'h7, 4'h7);
    check("R11 max pos sq n8", p8, 16'h3F01);
    check("R11 max pos sq n4", {8'h0, p4}, 16'h0031);
    cycle(1'b1, 8'h7F, 8'h81, 4'h7, 4'h9);
    check("R11 max pos x min n8", p8, 16'hC0FF);
    check("R11 max pos x min n4", {8'h0, p4}, 16'h00CF);

    // R1: reset in mid-run clears a nonzero product
    cycle(1'b0, 8'h12, 8'h34, 4'h5, 4'h6);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset n8", p8, 16'h0);
    check("R1 mid reset n4", {8'h0, p4}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule